// File: doc/BRIEF.md
# Serial Frame CRC Unit

This block runs a cyclic redundancy check next to a serial shift engine. It keeps two accumulators, one for the transmit stream and one for the receive stream. Both divide by a programmable generator polynomial. The engine pulses a load strobe each time it takes a new outgoing frame, and a receive strobe each time an incoming frame has been assembled. The unit folds each frame into the matching accumulator, most significant bit first.

Software can request that the transmit remainder go out as the next frame. The unit then places the remainder on the outgoing frame bus for the next load and marks it as a check frame. The next received frame is taken as the peer's check value. After that frame has been folded into the receive accumulator, a non-zero remainder raises a sticky error flag. Software clears the flag with a clear pulse. The length select sets both the frame width and the remainder width: 8 bits (the low byte of each frame) or 16 bits.

Top module: `crc_frame_unit`

## Requirements
- R1: After reset the polynomial register reads 0x0007. A write pulse loads a new 16-bit value, which is read back on the cycle after the write. Without a write the value does not change.
- R2: Each data frame is folded in most significant bit first, one step per data bit. Each step shifts the remainder left by one and XORs in the polynomial when the bit leaving the top of the remainder differs from the data bit. With the length select at 1, all 16 frame bits and all 16 polynomial bits are used. With it at 0, only bits 7:0 of the frame, the remainder and the polynomial are used, and bits 15:8 of the remainder read zero.
- R3: While the enable input is 0, frame strobes leave both accumulators unchanged.
- R4: On the first cycle that the enable input is 1 after being 0, both accumulators become zero. Frames strobed on that same cycle are not folded in.
- R5: A transmit load updates only the transmit accumulator. A receive strobe updates only the receive accumulator. Both values are always visible on their own outputs.
- R6: While a send request is pending, the next transmit load sees the transmit remainder on the outgoing frame bus and the check-frame marker set to 1. That load leaves the transmit accumulator unchanged. With no request pending, the frame bus carries the input data word and the marker is 0.
- R7: A send request pulse makes the pending flag 1 from the next cycle. The flag returns to 0 after the transmit load that carries the check frame.
- R8: The first receive strobe after a check frame has been loaded is checked. If the receive accumulator is non-zero after that frame has been folded in, the error flag becomes 1. A remainder of zero leaves the flag at 0.
- R9: The error flag stays at 1 through later frames until an error clear pulse, which makes it 0 on the next cycle.
- R10: After reset both accumulators read 0, and the pending flag and the error flag read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poly_we | input | 1 | Polynomial write strobe |
| poly_wdata | input | 16 | Polynomial write value |
| crc_en | input | 1 | Accumulation enable (level) |
| len16 | input | 1 | 1 selects 16-bit frames and remainder, 0 selects 8-bit |
| send_req | input | 1 | One-cycle request to send the transmit remainder next |
| err_clr | input | 1 | One-cycle clear of the error flag |
| tx_load | input | 1 | Shift engine takes the next outgoing frame |
| tx_wdata | input | 16 | Next data word from the transmit buffer |
| tx_frame | output | 16 | Frame handed to the shift engine |
| tx_is_crc | output | 1 | The handed frame is the check frame |
| rx_strobe | input | 1 | A received frame is complete |
| rx_data | input | 16 | Received frame |
| poly_q | output | 16 | Polynomial register |
| tx_crc | output | 16 | Transmit accumulator |
| rx_crc | output | 16 | Receive accumulator |
| send_pending | output | 1 | Send request is waiting for a load |
| crc_err | output | 1 | Sticky check-mismatch flag |

## Verification
The folding function is tried with two-frame messages in both lengths and with several polynomials. Narrow messages whose frames carry junk in the upper byte show whether the byte mask is applied. A narrow run with a polynomial whose upper byte is non-zero shows that only the low byte of the polynomial is used. A single bit in the lowest or the highest frame position separates the shift direction and the feedback tap, and the known values 0x89 and 0x1021 catch a reversed bit order. A full exchange in which the receive side is fed the sent remainder must leave zero and no error. Corrupting the check frame by one bit must raise the flag, and the flag must stay set across a later frame until it is cleared.

// File: rtl/crc_frame_unit.sv
module crc_frame_unit #(
  parameter int CW = 16,
  parameter int NW = 8,
  parameter logic [CW-1:0] POLY_RST = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poly_we,
  input  logic [CW-1:0] poly_wdata,
  input  logic          crc_en,
  input  logic          len16,
  input  logic          send_req,
  input  logic          err_clr,
  input  logic          tx_load,
  input  logic [CW-1:0] tx_wdata,
  output logic [CW-1:0] tx_frame,
  output logic          tx_is_crc,
  input  logic          rx_strobe,
  input  logic [CW-1:0] rx_data,
  output logic [CW-1:0] poly_q,
  output logic [CW-1:0] tx_crc,
  output logic [CW-1:0] rx_crc,
  output logic          send_pending,
  output logic          crc_err
);

  localparam logic [CW-1:0] NMASK = {{(CW-NW){1'b0}}, {NW{1'b1}}};

  function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c,
                                             input logic [CW-1:0] d,
                                             input logic [CW-1:0] p,
                                             input logic wide);
    logic [CW-1:0] r;
    logic fb;
    r = wide ? c : (c & NMASK);
    for (int i = CW-1; i >= 0; i--) begin
      if (wide || i < NW) begin
        fb = (wide ? r[CW-1] : r[NW-1]) ^ d[i];
        r  = {r[CW-2:0], 1'b0} ^ (fb ? p : '0);
        if (!wide) r = r & NMASK;
      end
    end
    return r;
  endfunction

  logic          en_q;
  logic          rx_expect;
  logic [CW-1:0] tx_next, rx_next;
  logic          acc_on, acc_clr, crc_load;

  assign acc_on   = crc_en & en_q;
  assign acc_clr  = crc_en & ~en_q;
  assign crc_load = tx_load & send_pending;
  assign tx_next  = crc_step(tx_crc, tx_wdata, poly_q, len16);
  assign rx_next  = crc_step(rx_crc, rx_data, poly_q, len16);

  assign tx_frame  = send_pending ? tx_crc : tx_wdata;
  assign tx_is_crc = send_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      poly_q       <= POLY_RST;
      tx_crc       <= '0;
      rx_crc       <= '0;
      send_pending <= 1'b0;
      rx_expect    <= 1'b0;
      crc_err      <= 1'b0;
    end else begin
      en_q <= crc_en;
      if (poly_we) poly_q <= poly_wdata;

      if (acc_clr) begin
        tx_crc <= '0;
        rx_crc <= '0;
      end else begin
        if (acc_on && tx_load && !send_pending) tx_crc <= tx_next;
        if (acc_on && rx_strobe)                rx_crc <= rx_next;
      end

      if (crc_load) send_pending <= 1'b0;
      if (send_req) send_pending <= 1'b1;

      if (rx_strobe) rx_expect <= 1'b0;
      if (crc_load)  rx_expect <= 1'b1;

      if (err_clr) crc_err <= 1'b0;
      if (rx_strobe && rx_expect && acc_on && rx_next != '0) crc_err <= 1'b1;
    end
  end

endmodule

// File: rtl/crc_frame_unit_chk.sv
module crc_frame_unit_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          crc_en,
  input logic          send_req,
  input logic          err_clr,
  input logic          tx_load,
  input logic          tx_is_crc,
  input logic          rx_strobe,
  input logic          poly_we,
  input logic [CW-1:0] poly_q,
  input logic [CW-1:0] tx_crc,
  input logic [CW-1:0] rx_crc,
  input logic          send_pending,
  input logic          crc_err
);

  // R1
  poly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poly_we |=> $stable(poly_q));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_en |=> ($stable(tx_crc) && $stable(rx_crc)));

  // R4
  en_rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_en) |=> (tx_crc == '0 && rx_crc == '0));

  // R6
  crc_frame_no_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_is_crc && !$rose(crc_en)) |=> $stable(tx_crc));

  // R7
  pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |=> send_pending);

  // R7
  pending_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && send_pending && !send_req) |=> !send_pending);

  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(rx_strobe));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !err_clr) |=> crc_err);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_strobe) |=> !crc_err);

endmodule

bind crc_frame_unit crc_frame_unit_chk #(.CW(CW)) u_chk (.*);

// File: tb/test_crc_frame_unit.sv
`timescale 1ns/1ps
module test_crc_frame_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poly_we = 1'b0;
  logic [15:0] poly_wdata = '0;
  logic        crc_en = 1'b0;
  logic        len16 = 1'b0;
  logic        send_req = 1'b0;
  logic        err_clr = 1'b0;
  logic        tx_load = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic [15:0] tx_frame;
  logic        tx_is_crc;
  logic        rx_strobe = 1'b0;
  logic [15:0] rx_data = '0;
  logic [15:0] poly_q, tx_crc, rx_crc;
  logic        send_pending, crc_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  crc_frame_unit i_crc_frame_unit (.*);

  // {wide, poly, frame0, frame1}
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 16'h0007, 16'h0031, 16'h00C2},
    {1'b0, 16'h001D, 16'h00FF, 16'h0000},
    {1'b0, 16'h0031, 16'h0055, 16'h00AA},
    {1'b0, 16'h009B, 16'hA5C3, 16'h7E18},
    {1'b1, 16'h1021, 16'h1234, 16'hABCD},
    {1'b1, 16'h8005, 16'hFFFF, 16'h0001},
    {1'b1, 16'h8BB7, 16'h0000, 16'h8000},
    {1'b1, 16'h3D65, 16'hC001, 16'h0F0F}
  };

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d,
                                          input logic [15:0] p, input logic wide);
    int nb;
    logic [15:0] msk, acc;
    logic b;
    nb  = wide ? 16 : 8;
    msk = wide ? 16'hFFFF : 16'h00FF;
    acc = c & msk;
    for (int k = nb - 1; k >= 0; k--) begin
      b   = acc[nb-1] ^ d[k];
      acc = ((acc << 1) ^ (b ? p : 16'h0000)) & msk;
    end
    return acc;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic en_restart;
    crc_en = 1'b0; tick();
    crc_en = 1'b1; tick();
  endtask

  task automatic set_poly(input logic [15:0] p);
    poly_we = 1'b1; poly_wdata = p; tick(); poly_we = 1'b0;
  endtask

  task automatic tx_send(input logic [15:0] d, output logic [15:0] seen, output logic mark);
    tx_load = 1'b1; tx_wdata = d;
    #1;
    seen = tx_frame; mark = tx_is_crc;
    tick();
    tx_load = 1'b0;
  endtask

  task automatic rx_send(input logic [15:0] d);
    rx_strobe = 1'b1; rx_data = d; tick(); rx_strobe = 1'b0;
  endtask

  task automatic both_send(input logic [15:0] d);
    tx_load = 1'b1; tx_wdata = d; rx_strobe = 1'b1; rx_data = d;
    tick();
    tx_load = 1'b0; rx_strobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen, exp, e1;
    logic mark;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 and R1: values after reset
    check("R1 poly reset", poly_q, 16'h0007);
    check("R10 tx_crc reset", tx_crc, 16'h0000);
    check("R10 rx_crc reset", rx_crc, 16'h0000);
    check("R10 flags reset", {14'b0, send_pending, crc_err}, 16'h0000);

    // R2, R5: table walk
    for (int v = 0; v < 8; v++) begin
      len16 = VEC[v][48];
      set_poly(VEC[v][47:32]);
      check("R1 poly write", poly_q, VEC[v][47:32]);
      en_restart();
      exp = ref_crc(ref_crc(16'h0, VEC[v][31:16], VEC[v][47:32], VEC[v][48]),
                    VEC[v][15:0], VEC[v][47:32], VEC[v][48]);
      tx_send(VEC[v][31:16], seen, mark);
      tx_send(VEC[v][15:0], seen, mark);
      check("R5 rx untouched by tx loads", rx_crc, 16'h0000);
      check("R2 tx remainder", tx_crc, exp);
      rx_send(VEC[v][31:16]);
      rx_send(VEC[v][15:0]);
      check("R2 rx remainder", rx_crc, exp);
      check("R5 tx untouched by rx frames", tx_crc, exp);
    end

    // R2 anchors: known values and the narrow polynomial mask
    len16 = 1'b0; set_poly(16'h0007); en_restart();
    both_send(16'h0080);
    check("R2 narrow 0x80 poly 07", tx_crc, 16'h0089);
    set_poly(16'hFF07); en_restart();
    both_send(16'h0080);
    check("R2 narrow uses low poly byte", rx_crc, 16'h0089);
    len16 = 1'b1; set_poly(16'h1021); en_restart();
    both_send(16'h0001);
    check("R2 wide lowest bit", tx_crc, 16'h1021);

    // R3: disabled, frames ignored
    crc_en = 1'b0; tick();
    both_send(16'hDEAD);
    check("R3 tx held when disabled", tx_crc, 16'h1021);
    check("R3 rx held when disabled", rx_crc, 16'h1021);

    // R4: rising enable clears, frames on that cycle ignored
    crc_en = 1'b1;
    both_send(16'h7777);
    check("R4 tx cleared on enable", tx_crc, 16'h0000);
    check("R4 rx cleared on enable", rx_crc, 16'h0000);

    // R6, R7, R8: good exchange
    en_restart();
    both_send(16'hBEEF);
    both_send(16'h0042);
    exp = ref_crc(ref_crc(16'h0, 16'hBEEF, 16'h1021, 1'b1), 16'h0042, 16'h1021, 1'b1);
    tx_send(16'h3333, seen, mark);
    check("R6 data frame passes through", seen, 16'h3333);
    check("R6 data frame marker low", {15'b0, mark}, 16'h0000);
    exp = ref_crc(exp, 16'h3333, 16'h1021, 1'b1);
    rx_send(16'h3333);
    send_req = 1'b1; tick(); send_req = 1'b0;
    check("R7 pending after request", {15'b0, send_pending}, 16'h0001);
    tx_send(16'h5555, seen, mark);
    check("R6 check frame value", seen, exp);
    check("R6 check frame marker", {15'b0, mark}, 16'h0001);
    check("R7 pending cleared", {15'b0, send_pending}, 16'h0000);
    check("R6 tx not folded with check frame", tx_crc, exp);
    rx_send(exp);
    check("R8 rx remainder zero", rx_crc, 16'h0000);
    check("R8 no error on match", {15'b0, crc_err}, 16'h0000);

    // R8, R9: corrupted check frame, narrow mode
    len16 = 1'b0; set_poly(16'h0007); en_restart();
    both_send(16'h000F);
    e1 = ref_crc(16'h0, 16'h000F, 16'h0007, 1'b0);
    send_req = 1'b1; tick(); send_req = 1'b0;
    tx_send(16'h0000, seen, mark);
    check("R6 narrow check frame", seen, e1);
    rx_send(e1 ^ 16'h0001);
    check("R8 error on mismatch", {15'b0, crc_err}, 16'h0001);
    rx_send(16'h0011);
    check("R9 error sticky", {15'b0, crc_err}, 16'h0001);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    check("R9 error cleared", {15'b0, crc_err}, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule